// File: doc/BRIEF.md
# Host Port Memory Window Slave

This block gives an external host access to an internal word memory and to a pair of mailboxes through four 16-bit registers, selected by a 2-bit index. The host first loads a byte address into the address register. It then streams reads or writes through the data register. The pointer steps forward one word after each data access, so a block transfer needs only one address write.

Two mailboxes carry messages between the host and the device logic. A value written by the host reaches the device side over a valid/ready pair, and a pending flag is raised. A value posted by the device raises a flag and an interrupt line to the host. A host read of the mailbox register returns that value and clears the flag.

Host accesses must keep a minimum spacing. An access that arrives too soon after the previous one is consumed and dropped without effect, and a sticky violation flag is set.

The host request channel is valid/ready. `req_ready` falls while a read response waits for `rsp_ready`, and it rises again on the cycle after that response is taken. The response channel holds `rsp_valid` and `rsp_rdata` steady until `rsp_ready` is high. A write never produces a response. The device-bound mailbox holds `dev_in_valid` and `dev_in_data` until `dev_in_ready` is high.

Top module: `hostport_slave`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid`, `host_irq`, `gap_violation` and `dev_in_valid` are all 0.
- R2: The register index selects the target: 0 is the data window, 1 is the mailbox, 2 is the address pointer and 3 is status. A write to the status register has no effect.
- R3: Writing index 2 loads the pointer. Each accepted data access (index 0) reads or writes the word at the pointer and then advances it by 2 bytes. Reading index 2 returns the current byte address.
- R4: Bit 0 of a written address is ignored, so every access is word aligned.
- R5: The pointer wraps modulo 2^ADDR_BITS bytes. With the default of 1024, a burst from byte 0x3FE continues at byte 0.
- R6: A host write to index 1 drives `dev_in_valid` high, with `dev_in_data` equal to the written value, on the next cycle. Both hold until `dev_in_ready` is seen high, which clears them.
- R7: The status word has the outgoing-mailbox flag at bit 0, the incoming-mailbox-pending flag at bit 1 and the spacing-violation flag at bit 2. All other bits read as 0.
- R8: A `dev_post` pulse stores `dev_post_data` and sets the outgoing flag. `host_irq` equals that flag. A host read of index 1 returns the stored value and clears the flag. If a post arrives on the same cycle as that read, the post wins.
- R9: An accepted access that comes fewer than MIN_GAP cycles after the previous accepted access is dropped. It causes no memory change, no pointer change and no response, and it sets `gap_violation`.
- R10: `gap_violation` stays set until the host reads the status register. That read returns the flag still set and clears it.
- R11: A read response is available on the cycle after the request handshake. While `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold steady and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 2 | Register index |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 16 | Read response data |
| dev_post | input | 1 | Device posts an outgoing mailbox word |
| dev_post_data | input | 16 | Word posted by the device |
| dev_in_valid | output | 1 | Host-written mailbox word pending |
| dev_in_ready | input | 1 | Device consumes the pending word |
| dev_in_data | output | 16 | Host-written mailbox word |
| host_irq | output | 1 | High while the outgoing mailbox is full |
| gap_violation | output | 1 | Sticky spacing-violation flag |

## Verification
A read response appears one cycle after its request handshake and then holds until it is taken. Mailbox flags, `host_irq` and `gap_violation` change on the clock edge that follows the causing event. The bench drives on falling edges and lets the monitor pop expected responses only on falling edges where `rsp_valid` and `rsp_ready` are both high, so every comparison is made half a cycle after the edge that produced the value. Direct checks on flags are made at least one full falling edge after the handshake that caused them.

// File: rtl/hps_pkg.sv
package hps_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_MBOX = 2'd1,
    REG_ADDR = 2'd2,
    REG_STAT = 2'd3
  } hps_reg_e;

  localparam int STAT_OUT_BIT  = 0;
  localparam int STAT_IN_BIT   = 1;
  localparam int STAT_VIOL_BIT = 2;
endpackage

// File: rtl/hps_pacer.sv
// Enforces minimum spacing between accepted host accesses and keeps the
// sticky violation flag.
module hps_pacer #(
  parameter int MIN_GAP = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs,
  input  logic viol_clr,
  output logic access_ok,
  output logic viol
);
  localparam int CW = $clog2(MIN_GAP + 1);
  localparam logic [CW-1:0] GAP_MAX = CW'(MIN_GAP);

  logic [CW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               since_q <= GAP_MAX;
    else if (hs)              since_q <= CW'(1);
    else if (since_q < GAP_MAX) since_q <= since_q + CW'(1);
  end

  assign access_ok = (since_q >= GAP_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)                 viol <= 1'b0;
    else if (hs && !access_ok)  viol <= 1'b1;
    else if (viol_clr)          viol <= 1'b0;
  end

  assert_viol_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !access_ok) |=> viol);
  assert_back_to_back_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> (MIN_GAP <= 1) || !access_ok);
  assert_viol_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !viol_clr) |=> viol);
endmodule

// File: rtl/hps_mailbox.sv
// Two one-word mailboxes: host to device and device to host.
module hps_mailbox #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_wr,
  input  logic         host_rd,
  input  logic [W-1:0] host_wdata,
  input  logic         dev_post,
  input  logic [W-1:0] dev_post_data,
  output logic [W-1:0] out_data,
  output logic         out_flag,
  output logic         in_valid,
  input  logic         in_ready,
  output logic [W-1:0] in_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data <= '0;
      out_flag <= 1'b0;
    end else if (dev_post) begin
      out_data <= dev_post_data;
      out_flag <= 1'b1;
    end else if (host_rd) begin
      out_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_data  <= '0;
      in_valid <= 1'b0;
    end else if (host_wr) begin
      in_data  <= host_wdata;
      in_valid <= 1'b1;
    end else if (in_valid && in_ready) begin
      in_valid <= 1'b0;
    end
  end

  assert_post_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_post |=> out_flag);
  assert_read_clears_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !dev_post) |=> !out_flag);
  assert_host_write_delivers_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (in_valid && in_data == $past(host_wdata)));
  assert_in_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !host_wr) |=> (in_valid && $stable(in_data)));
endmodule

// File: rtl/hps_window.sv
// Auto-incrementing word pointer over a synchronous RAM.
module hps_window #(
  parameter int ADDR_BITS = 10,
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addr_wr,
  input  logic [W-1:0]         addr_wdata,
  input  logic                 data_wr,
  input  logic                 data_rd,
  input  logic [W-1:0]         wdata,
  output logic [W-1:0]         rdata,
  output logic [ADDR_BITS-1:0] ptr_byte
);
  localparam int WA    = ADDR_BITS - 1;
  localparam int DEPTH = 1 << WA;

  logic [WA-1:0] ptr_q;
  logic [W-1:0]  mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n)                 ptr_q <= '0;
    else if (addr_wr)           ptr_q <= addr_wdata[ADDR_BITS-1:1];
    else if (data_wr || data_rd) ptr_q <= ptr_q + WA'(1);
  end

  always_ff @(posedge clk) begin
    if (data_wr) mem[ptr_q] <= wdata;
    if (data_rd) rdata <= mem[ptr_q];
  end

  assign ptr_byte = {ptr_q, 1'b0};

  assert_addr_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> ptr_byte == {$past(addr_wdata[ADDR_BITS-1:1]), 1'b0});
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_wr && (data_wr || data_rd)) |=>
      ptr_byte == ADDR_BITS'($past(ptr_byte) + ADDR_BITS'(2)));
  assert_no_dual_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_wr && data_rd));
endmodule

// File: rtl/hostport_slave.sv
module hostport_slave
  import hps_pkg::*;
#(
  parameter int ADDR_BITS = 10,
  parameter int MIN_GAP   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_idx,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  input  logic              dev_post,
  input  logic [WORD_W-1:0] dev_post_data,
  output logic              dev_in_valid,
  input  logic              dev_in_ready,
  output logic [WORD_W-1:0] dev_in_data,
  output logic              host_irq,
  output logic              gap_violation
);
  logic hs, access_ok, go, go_rd, go_wr;
  logic viol, out_flag;
  logic [WORD_W-1:0] out_data, ram_q, reg_q, stat_w;
  logic [ADDR_BITS-1:0] ptr_byte;
  logic rsp_pend, rsp_from_ram;
  hps_reg_e idx;

  assign idx       = hps_reg_e'(req_idx);
  assign req_ready = !rsp_pend;
  assign hs        = req_valid && req_ready;
  assign go        = hs && access_ok;
  assign go_rd     = go && !req_write;
  assign go_wr     = go && req_write;

  hps_pacer #(.MIN_GAP(MIN_GAP)) u_pacer (
    .clk(clk), .rst_n(rst_n), .hs(hs),
    .viol_clr(go_rd && idx == REG_STAT),
    .access_ok(access_ok), .viol(viol)
  );

  hps_mailbox #(.W(WORD_W)) u_mbox (
    .clk(clk), .rst_n(rst_n),
    .host_wr(go_wr && idx == REG_MBOX),
    .host_rd(go_rd && idx == REG_MBOX),
    .host_wdata(req_wdata),
    .dev_post(dev_post), .dev_post_data(dev_post_data),
    .out_data(out_data), .out_flag(out_flag),
    .in_valid(dev_in_valid), .in_ready(dev_in_ready), .in_data(dev_in_data)
  );

  hps_window #(.ADDR_BITS(ADDR_BITS), .W(WORD_W)) u_win (
    .clk(clk), .rst_n(rst_n),
    .addr_wr(go_wr && idx == REG_ADDR), .addr_wdata(req_wdata),
    .data_wr(go_wr && idx == REG_DATA), .data_rd(go_rd && idx == REG_DATA),
    .wdata(req_wdata), .rdata(ram_q), .ptr_byte(ptr_byte)
  );

  always_comb begin
    stat_w = '0;
    stat_w[STAT_OUT_BIT]  = out_flag;
    stat_w[STAT_IN_BIT]   = dev_in_valid;
    stat_w[STAT_VIOL_BIT] = viol;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_pend     <= 1'b0;
      rsp_from_ram <= 1'b0;
      reg_q        <= '0;
    end else if (go_rd) begin
      rsp_pend     <= 1'b1;
      rsp_from_ram <= (idx == REG_DATA);
      case (idx)
        REG_MBOX: reg_q <= out_data;
        REG_ADDR: reg_q <= WORD_W'(ptr_byte);
        REG_STAT: reg_q <= stat_w;
        default:  reg_q <= '0;
      endcase
    end else if (rsp_pend && rsp_ready) begin
      rsp_pend <= 1'b0;
    end
  end

  assign rsp_valid     = rsp_pend;
  assign rsp_rdata     = rsp_from_ram ? ram_q : reg_q;
  assign host_irq      = out_flag;
  assign gap_violation = viol;

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  assert_ready_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  assert_read_responds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    go_rd |=> rsp_valid);
  assert_drop_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !access_ok) |=> !rsp_valid);
  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_post |=> host_irq);
endmodule

// File: tb/test_hostport_slave.sv
`timescale 1ns/1ps
module test_hostport_slave;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [1:0] req_idx = 0;
  logic [15:0] req_wdata = 0, dev_post_data = 0;
  logic dev_post = 0, dev_in_ready = 0;
  logic req_ready, rsp_valid, dev_in_valid, host_irq, gap_violation;
  logic [15:0] rsp_rdata, dev_in_data;

  int checks = 0, failures = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  hostport_slave #(.ADDR_BITS(10), .MIN_GAP(6)) i_hostport_slave (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_idx(req_idx), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .dev_post(dev_post), .dev_post_data(dev_post_data),
    .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
    .dev_in_data(dev_in_data), .host_irq(host_irq), .gap_violation(gap_violation)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk("unexpected response", rsp_rdata, 16'hxxxx);
      else chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  // Driver: one access, then idle so the next handshake comes `spacing` cycles later
  task automatic acc(input bit wr, input logic [1:0] idx, input logic [15:0] d,
                     input int spacing, input string tag, input logic [15:0] exp);
    if (!wr) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_idx = idx; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    repeat (spacing - 2) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] idx, input logic [15:0] d);
    acc(1, idx, d, 6, "", 16'h0);
  endtask
  task automatic rd(input logic [1:0] idx, input string tag, input logic [15:0] exp);
    acc(0, idx, 16'h0, 6, tag, exp);
  endtask

  bit done = 0;
  initial begin
    #200000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", 16'(req_ready), 16'h1);
    chk("R1 rsp_valid", 16'(rsp_valid), 16'h0);
    chk("R1 host_irq", 16'(host_irq), 16'h0);
    chk("R1 gap_violation", 16'(gap_violation), 16'h0);
    chk("R1 dev_in_valid", 16'(dev_in_valid), 16'h0);

    // R2 R3 burst write then burst read; R4 odd address
    wr(2, 16'h0010);
    wr(0, 16'hA001); wr(0, 16'hB002); wr(0, 16'hC003);
    rd(2, "R3 pointer after writes", 16'h0016);
    wr(2, 16'h0011);
    rd(2, "R4 bit0 ignored", 16'h0010);
    rd(0, "R3 word0", 16'hA001);
    rd(0, "R3 word1", 16'hB002);
    rd(0, "R3 word2", 16'hC003);
    wr(3, 16'hFFFF);
    rd(3, "R2 status write ignored", 16'h0000);

    // R5 wrap
    wr(2, 16'h03FE);
    wr(0, 16'h1111); wr(0, 16'h2222);
    rd(2, "R5 pointer wrapped", 16'h0002);
    wr(2, 16'h0000);
    rd(0, "R5 word at zero", 16'h2222);
    wr(2, 16'h03FE);
    rd(0, "R5 last word", 16'h1111);

    // R6 host to device mailbox
    wr(1, 16'h1234);
    chk("R6 dev_in_valid", 16'(dev_in_valid), 16'h1);
    chk("R6 dev_in_data", dev_in_data, 16'h1234);
    rd(3, "R7 in-pending bit1", 16'h0002);
    chk("R6 held", 16'(dev_in_valid), 16'h1);
    dev_in_ready = 1; @(negedge clk); dev_in_ready = 0;
    chk("R6 consumed", 16'(dev_in_valid), 16'h0);

    // R7 R8 device to host mailbox
    dev_post_data = 16'hBEEF; dev_post = 1; @(negedge clk); dev_post = 0;
    chk("R8 irq set", 16'(host_irq), 16'h1);
    rd(3, "R7 out bit0", 16'h0001);
    rd(1, "R8 mailbox value", 16'hBEEF);
    chk("R8 irq cleared", 16'(host_irq), 16'h0);
    rd(3, "R7 status clear", 16'h0000);

    // R9 spacing violation: middle write dropped
    wr(2, 16'h0040);
    acc(1, 0, 16'h5555, 2, "", 16'h0);
    acc(1, 0, 16'h6666, 6, "", 16'h0);
    chk("R9 violation flag", 16'(gap_violation), 16'h1);
    wr(0, 16'h7777);
    wr(2, 16'h0040);
    rd(0, "R9 first kept", 16'h5555);
    rd(0, "R9 dropped write had no effect", 16'h7777);
    // R10 status read returns then clears violation
    rd(3, "R10 status shows violation", 16'h0004);
    chk("R10 flag cleared", 16'(gap_violation), 16'h0);
    rd(3, "R10 status after clear", 16'h0000);

    // R11 back-pressure
    wr(2, 16'h0010);
    @(negedge clk); rsp_ready = 0;
    acc(0, 0, 16'h0, 4, "R11 held response", 16'hA001);
    chk("R11 rsp_valid held", 16'(rsp_valid), 16'h1);
    chk("R11 req_ready low", 16'(req_ready), 16'h0);
    chk("R11 data stable", rsp_rdata, 16'hA001);
    rsp_ready = 1;
    repeat (4) @(negedge clk);
    chk("R11 req_ready back", 16'(req_ready), 16'h1);
    chk("scoreboard drained", 16'(exp_q.size()), 16'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule